// File: doc/BRIEF.md
# Table-Driven Byte Scan Engine

This engine walks a string of bytes held in an external byte memory. It uses each byte as an index into a separate 256-entry function table. The walk ends at the first byte whose table entry is nonzero. A caller supplies a start address, a length written as one less than the true byte count, a direction, and the current contents of two result registers. The caller then pulses a start strobe.

The engine examines one byte at a time. It first reads the operand memory, then presents the fetched byte as the table address, then inspects the table byte that comes back. When the walk ends, the engine raises a one-cycle done pulse together with a condition code. On a stop it also writes the updated result registers: the first receives the stopping byte's address, and the low byte of the second receives the table entry found. Both memories are only read, never written.

Top module: `tscan_engine`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, cc_o, gr1_o and gr2_o are all zero, and neither read enable is high.
- R2: A start_i pulse while idle is accepted and busy_o is high in the following cycle. A start_i pulse while busy_o is high is ignored: it changes neither the addresses read nor the result.
- R3: When rev_i is 0, bytes are read at ascending addresses from start_addr_i. Addresses wrap modulo 2^AW.
- R4: When rev_i is 1, bytes are read at descending addresses from start_addr_i + len_m1_i down to start_addr_i, wrapping modulo 2^AW.
- R5: len_m1_i holds the true length minus one. The value 0 means exactly one byte and 255 means 256 bytes. No byte outside that range is read.
- R6: For every operand byte read, the next cycle raises tbl_re_o with tbl_addr_o equal to that operand byte.
- R7: The scan stops at the first byte in scan order whose table entry is nonzero. gr1_o then becomes the byte's address zero-extended to RW bits, and gr2_o[7:0] becomes the table entry. gr2_o[RW-1:8] keeps the value taken from gr2_i at start.
- R8: cc_o is 1 if the stop byte is not the last in scan order, and 2 if it is the last. cc_o is 0 if all entries were zero; in that case gr1_o and gr2_o equal gr1_i and gr2_i as captured at start. The value 3 never occurs.
- R9: Each byte takes three cycles. With k bytes examined, done_o is high for exactly one cycle, after the 3k-th rising edge following the edge that accepted start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_addr_i | input | AW | Lowest address of the string |
| len_m1_i | input | LW | Byte count minus one |
| rev_i | input | 1 | 0: ascending scan, 1: descending scan |
| gr1_i | input | RW | Address result register contents at start |
| gr2_i | input | RW | Function-byte result register contents at start |
| opnd_re_o | output | 1 | Operand memory read enable |
| opnd_addr_o | output | AW | Operand memory address |
| opnd_data_i | input | 8 | Operand byte, valid one cycle after the read |
| tbl_re_o | output | 1 | Table memory read enable |
| tbl_addr_o | output | 8 | Table index |
| tbl_data_i | input | 8 | Table entry, valid one cycle after the read |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code (0 none, 1 early stop, 2 stop on last byte) |
| gr1_o | output | RW | Address result register |
| gr2_o | output | RW | Function-byte result register |

## Verification
The assertions check on every cycle the properties that do not depend on the data:
- the address step between consecutive operand reads in each direction;
- a table read always following an operand read;
- the register update on a nonzero entry;
- the single-cycle done pulse;
- the absence of code 3.

Several outcomes can only be seen across a whole scan, so only the bench scenarios show them:
- which of two nonzero entries wins in each direction;
- the early versus last-byte code;
- the unchanged registers when nothing matches;
- wrap-around at the top of the address space;
- the one-byte length case;
- that a start pulse in mid-scan is ignored.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPND = 2'd1,
        ST_TBL  = 2'd2,
        ST_CHK  = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic hit;
        logic last;
    } verdict_t;

    localparam logic [1:0] CC_NONE  = 2'd0;
    localparam logic [1:0] CC_EARLY = 2'd1;
    localparam logic [1:0] CC_LAST  = 2'd2;

    function automatic logic [1:0] cc_of(verdict_t v);
        if (!v.hit)
            return CC_NONE;
        return v.last ? CC_LAST : CC_EARLY;
    endfunction

endpackage

// File: rtl/tscan_ctrl.sv
module tscan_ctrl
    import tscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        is_last_i,
    input  logic        fn_nz_i,
    output scan_state_e st_o,
    output logic        accept_o,
    output logic        step_o,
    output logic        finish_o,
    output verdict_t    verdict_o
);

    scan_state_e st_q, st_d;

    always_comb begin
        accept_o       = (st_q == ST_IDLE) && start_i;
        finish_o       = (st_q == ST_CHK) && (fn_nz_i || is_last_i);
        step_o         = (st_q == ST_CHK) && !fn_nz_i && !is_last_i;
        verdict_o.hit  = fn_nz_i;
        verdict_o.last = is_last_i;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_i) st_d = ST_OPND;
            ST_OPND: st_d = ST_TBL;
            ST_TBL:  st_d = ST_CHK;
            ST_CHK:  st_d = finish_o ? ST_IDLE : ST_OPND;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign st_o = st_q;

    // R6: the table read always follows an operand read
    assert_table_after_operand_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OPND) |=> (st_q == ST_TBL));

    // R2: a running scan cannot be restarted before its check cycle
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TBL) |=> (st_q == ST_CHK));

endmodule

// File: rtl/tscan_walker.sv
module tscan_walker #(
    parameter int AW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  logic          step_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [LW-1:0] len_m1_i,
    input  logic          rev_i,
    output logic [AW-1:0] cur_addr_o,
    output logic          is_last_o,
    output logic          rev_o
);

    logic [AW-1:0] cur_q;
    logic [LW-1:0] rem_q;
    logic          rev_q;
    logic [AW-1:0] end_addr;

    assign end_addr = start_addr_i + AW'(len_m1_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            rem_q <= '0;
            rev_q <= 1'b0;
        end else if (accept_i) begin
            cur_q <= rev_i ? end_addr : start_addr_i;
            rem_q <= len_m1_i;
            rev_q <= rev_i;
        end else if (step_i) begin
            cur_q <= rev_q ? cur_q - AW'(1) : cur_q + AW'(1);
            rem_q <= rem_q - LW'(1);
        end
    end

    assign cur_addr_o = cur_q;
    assign is_last_o  = (rem_q == '0);
    assign rev_o      = rev_q;

endmodule

// File: rtl/tscan_result.sv
module tscan_result
    import tscan_pkg::*;
#(
    parameter int AW = 16,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  logic          finish_i,
    input  verdict_t      verdict_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    fn_i,
    input  logic [RW-1:0] gr1_i,
    input  logic [RW-1:0] gr2_i,
    output logic [RW-1:0] gr1_o,
    output logic [RW-1:0] gr2_o,
    output logic [1:0]    cc_o,
    output logic          done_o
);

    logic [RW-1:0] gr1_q, gr2_q;
    logic [1:0]    cc_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gr1_q  <= '0;
            gr2_q  <= '0;
            cc_q   <= CC_NONE;
            done_q <= 1'b0;
        end else begin
            done_q <= finish_i;
            if (accept_i) begin
                gr1_q <= gr1_i;
                gr2_q <= gr2_i;
            end else if (finish_i) begin
                cc_q <= cc_of(verdict_i);
                if (verdict_i.hit) begin
                    gr1_q      <= RW'(addr_i);
                    gr2_q[7:0] <= fn_i;
                end
            end
        end
    end

    assign gr1_o  = gr1_q;
    assign gr2_o  = gr2_q;
    assign cc_o   = cc_q;
    assign done_o = done_q;

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: code 3 is never reported
    assert_cc_legal_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cc_q != 2'd3));

endmodule

// File: rtl/tscan_engine.sv
module tscan_engine
    import tscan_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 8,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [LW-1:0] len_m1_i,
    input  logic          rev_i,
    input  logic [RW-1:0] gr1_i,
    input  logic [RW-1:0] gr2_i,
    output logic          opnd_re_o,
    output logic [AW-1:0] opnd_addr_o,
    input  logic [7:0]    opnd_data_i,
    output logic          tbl_re_o,
    output logic [7:0]    tbl_addr_o,
    input  logic [7:0]    tbl_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    cc_o,
    output logic [RW-1:0] gr1_o,
    output logic [RW-1:0] gr2_o
);

    scan_state_e   st;
    logic          accept, step, finish, is_last, rev_q, fn_nz;
    verdict_t      verdict;
    logic [AW-1:0] cur_addr;

    assign fn_nz = (tbl_data_i != 8'h00);

    tscan_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .is_last_i (is_last),
        .fn_nz_i   (fn_nz),
        .st_o      (st),
        .accept_o  (accept),
        .step_o    (step),
        .finish_o  (finish),
        .verdict_o (verdict)
    );

    tscan_walker #(.AW(AW), .LW(LW)) u_walker (
        .clk          (clk),
        .rst          (rst),
        .accept_i     (accept),
        .step_i       (step),
        .start_addr_i (start_addr_i),
        .len_m1_i     (len_m1_i),
        .rev_i        (rev_i),
        .cur_addr_o   (cur_addr),
        .is_last_o    (is_last),
        .rev_o        (rev_q)
    );

    tscan_result #(.AW(AW), .RW(RW)) u_result (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .finish_i  (finish),
        .verdict_i (verdict),
        .addr_i    (cur_addr),
        .fn_i      (tbl_data_i),
        .gr1_i     (gr1_i),
        .gr2_i     (gr2_i),
        .gr1_o     (gr1_o),
        .gr2_o     (gr2_o),
        .cc_o      (cc_o),
        .done_o    (done_o)
    );

    assign opnd_re_o   = (st == ST_OPND);
    assign opnd_addr_o = cur_addr;
    assign tbl_re_o    = (st == ST_TBL);
    assign tbl_addr_o  = opnd_data_i;
    assign busy_o      = (st != ST_IDLE);

    // R3: ascending scans read consecutive increasing addresses
    assert_ascend_step_R3: assert property (@(posedge clk) disable iff (rst)
        (opnd_re_o && $past(st) == ST_CHK && !rev_q)
            |-> (opnd_addr_o == $past(opnd_addr_o, 3) + AW'(1)));

    // R4: descending scans read consecutive decreasing addresses
    assert_descend_step_R4: assert property (@(posedge clk) disable iff (rst)
        (opnd_re_o && $past(st) == ST_CHK && rev_q)
            |-> (opnd_addr_o == $past(opnd_addr_o, 3) - AW'(1)));

    // R7: a nonzero entry ends the scan and lands in the result registers
    assert_stop_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHK && tbl_data_i != 8'h00)
            |=> (done_o && gr2_o[7:0] == $past(tbl_data_i)
                 && gr1_o == RW'($past(opnd_addr_o))));

endmodule

// File: tb/tscan_engine_tb.sv
module tscan_engine_tb_top;

    localparam int AW = 16;
    localparam int LW = 8;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [LW-1:0] len_m1_i = '0;
    logic          rev_i = 1'b0;
    logic [RW-1:0] gr1_i = '0;
    logic [RW-1:0] gr2_i = '0;
    logic          opnd_re_o, tbl_re_o, busy_o, done_o;
    logic [AW-1:0] opnd_addr_o;
    logic [7:0]    opnd_data_i, tbl_addr_o, tbl_data_i;
    logic [1:0]    cc_o;
    logic [RW-1:0] gr1_o, gr2_o;

    int checks = 0;
    int failures = 0;

    logic [7:0] omem [1024];
    logic [7:0] tmem [256];
    logic [7:0] oq, tq;

    logic [AW-1:0] exp_q [$];
    logic [7:0]    last_byte;
    logic          mon_on = 1'b0;

    always #2.5 clk = ~clk;

    tscan_engine #(.AW(AW), .LW(LW), .RW(RW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .len_m1_i(len_m1_i), .rev_i(rev_i), .gr1_i(gr1_i), .gr2_i(gr2_i),
        .opnd_re_o(opnd_re_o), .opnd_addr_o(opnd_addr_o), .opnd_data_i(opnd_data_i),
        .tbl_re_o(tbl_re_o), .tbl_addr_o(tbl_addr_o), .tbl_data_i(tbl_data_i),
        .busy_o(busy_o), .done_o(done_o), .cc_o(cc_o), .gr1_o(gr1_o), .gr2_o(gr2_o)
    );

    always @(posedge clk) begin
        if (opnd_re_o) oq <= omem[opnd_addr_o[9:0]];
        if (tbl_re_o)  tq <= tmem[tbl_addr_o];
    end
    assign opnd_data_i = oq;
    assign tbl_data_i  = tq;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of the read stream (R3 R4 R5 R6)
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (opnd_re_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 extra operand read", 64'(opnd_addr_o), 64'hFFFF_FFFF);
                end else begin
                    logic [AW-1:0] e;
                    e = exp_q.pop_front();
                    check(opnd_addr_o == e, "R3/R4 operand address", 64'(opnd_addr_o), 64'(e));
                    last_byte = omem[e[9:0]];
                end
            end
            if (tbl_re_o)
                check(tbl_addr_o == last_byte, "R6 table index", 64'(tbl_addr_o), 64'(last_byte));
        end
    end

    task automatic clear_tbl();
        for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    endtask

    task automatic set_hit(input logic [AW-1:0] a, input logic [7:0] fn);
        tmem[omem[a[9:0]]] = fn;
    endtask

    task automatic run_scan(input logic [AW-1:0] s, input logic [LW-1:0] l, input logic rv,
                            input logic [RW-1:0] g1, input logic [RW-1:0] g2, input bit inject,
                            input string tag);
        int n, k, cnt;
        logic [1:0] ecc;
        logic [RW-1:0] eg1, eg2;
        n = int'(l) + 1;
        k = n;
        ecc = 2'd0; eg1 = g1; eg2 = g2;
        exp_q.delete();
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            logic [7:0] f;
            a = rv ? AW'(s + AW'(l) - AW'(i)) : AW'(s + AW'(i));
            exp_q.push_back(a);
            f = tmem[omem[a[9:0]]];
            if (f != 8'h00) begin
                k = i + 1;
                ecc = (i == n - 1) ? 2'd2 : 2'd1;
                eg1 = RW'(a);
                eg2 = {g2[RW-1:8], f};
                break;
            end
        end
        @(negedge clk);
        start_i = 1'b1; start_addr_i = s; len_m1_i = l; rev_i = rv; gr1_i = g1; gr2_i = g2;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                start_i = 1'b0;
                check(busy_o == 1'b1, {"R2 busy after start ", tag}, 64'(busy_o), 64'd1);
            end
            if (inject && cnt == 3) begin
                start_i = 1'b1; start_addr_i = s + AW'(40); rev_i = ~rv; len_m1_i = 8'd2;
                gr1_i = ~g1; gr2_i = ~g2;
            end
            if (inject && cnt == 4) start_i = 1'b0;
        end while (!done_o && cnt < 4000);
        check(cnt == 3 * k + 1, {"R9 done latency ", tag}, 64'(cnt), 64'(3 * k + 1));
        check(cc_o == ecc, {"R8 condition code ", tag}, 64'(cc_o), 64'(ecc));
        check(gr1_o == eg1, {"R7 address result ", tag}, 64'(gr1_o), 64'(eg1));
        check(gr2_o == eg2, {"R7 function result ", tag}, 64'(gr2_o), 64'(eg2));
        check(exp_q.size() == 0, {"R5 bytes read ", tag}, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check(done_o == 1'b0, {"R9 done single pulse ", tag}, 64'(done_o), 64'd0);
        check(busy_o == 1'b0, {"R2 idle after done ", tag}, 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) omem[i] = 8'(i * 7 + 3);
        clear_tbl();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0 && done_o == 0, "R1 reset control", {busy_o, done_o}, 0);
        check(cc_o == 0 && gr1_o == 0 && gr2_o == 0, "R1 reset results", 64'(gr1_o ^ gr2_o) | 64'(cc_o), 0);
        check(!opnd_re_o && !tbl_re_o, "R1 reset reads", {opnd_re_o, tbl_re_o}, 0);
        mon_on = 1'b1;

        // R3 R7 R8 ascending, early stop
        clear_tbl(); set_hit(16'h0104, 8'h3C);
        run_scan(16'h0100, 8'd9, 1'b0, 32'h1111_2222, 32'hA5A5_A5A5, 0, "asc-early");
        // R7 first of two hits in ascending order
        clear_tbl(); set_hit(16'h0103, 8'h11); set_hit(16'h0107, 8'h22);
        run_scan(16'h0100, 8'd9, 1'b0, 32'h0, 32'hDEAD_BE00, 0, "asc-first");
        // R8 hit on last byte
        clear_tbl(); set_hit(16'h0109, 8'h80);
        run_scan(16'h0100, 8'd9, 1'b0, 32'h5, 32'h1234_5678, 0, "asc-last");
        // R8 nothing found, registers kept
        clear_tbl();
        run_scan(16'h0100, 8'd9, 1'b0, 32'hCAFE_0001, 32'hFEED_0002, 0, "asc-none");
        // R4 descending, first in descending order wins
        clear_tbl(); set_hit(16'h0202, 8'h01); set_hit(16'h0205, 8'h02);
        run_scan(16'h0200, 8'd7, 1'b1, 32'h7, 32'h8, 0, "desc-early");
        // R4 R8 descending last byte is the lowest address
        clear_tbl(); set_hit(16'h0200, 8'hFF);
        run_scan(16'h0200, 8'd7, 1'b1, 32'h9, 32'hABCD_EF00, 0, "desc-last");
        // R5 one-byte scans
        clear_tbl(); set_hit(16'h0300, 8'h44);
        run_scan(16'h0300, 8'd0, 1'b0, 32'h1, 32'h2, 0, "len1-hit");
        clear_tbl();
        run_scan(16'h0300, 8'd0, 1'b1, 32'h3, 32'h4, 0, "len1-none");
        // R3 wrap at the top of the address space
        clear_tbl(); set_hit(16'h0001, 8'h5E);
        run_scan(16'hFFFE, 8'd3, 1'b0, 32'h0, 32'h0, 0, "asc-wrap");
        // R4 wrap descending
        clear_tbl(); set_hit(16'hFFFF, 8'h6A);
        run_scan(16'hFFFE, 8'd3, 1'b1, 32'h0, 32'h0, 0, "desc-wrap");
        // R2 start during a scan is ignored
        clear_tbl(); set_hit(16'h0155, 8'h77);
        run_scan(16'h0150, 8'd9, 1'b0, 32'h10, 32'h20, 1, "ignored-start");
        // R5 maximum length, nothing found
        clear_tbl();
        run_scan(16'h0000, 8'd255, 1'b0, 32'h31, 32'h32, 0, "len256-none");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule